// File: doc/BRIEF.md
# Host Bridge Configuration Window Decoder

This block sits between a simple CPU bus and the configuration side of a PCI host bridge. It watches each CPU access and sorts it into one of three cases: an access that lands in a 4 MiB direct-mapped configuration window, a one-byte read of the interrupt-acknowledge location, or an access that hits nothing. A window access becomes a configuration request. Its bus-local address is built from the low register bits of the CPU address and a device number. The device number comes from a one-hot select bit in the CPU address, so software picks a device by setting a single address bit and no address register has to be written first.

Configuration data is little-endian. Byte enables and the write data are placed on the lanes chosen by the low two address bits. Read data is shifted back down and trimmed to the transfer size. A request is held until the target answers with a one-cycle done pulse, and the CPU sees its acknowledge and read data in that same cycle. A one-byte read of the acknowledge location asks an external interrupt controller for a vector and returns that vector. The block also swizzles the interrupt pins of each device onto the host interrupt lines by device number. This uses only two of the four lines.

Top module: `cfgwin_decoder`

## Requirements
- R1: An access whose address lies in [0x80800000, 0x80C00000) raises cfg_req in the cycle after the strobe is sampled, with cfg_we equal to the write strobe; addresses just outside that range raise no request.
- R2: cfg_addr[10:0] equals CPU address bits 10:0 of the access.
- R3: cfg_addr[14:11] equals the index (0..10) of the lowest set bit among CPU address bits 21:11, counted from bit 11, or 11 when none of those bits is set.
- R4: Size code 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. cfg_be is the size mask (0001, 0011, 1111) shifted left by address bits 1:0 and cut to four bits. cfg_wdata is cpu_wdata shifted left by 8 times address bits 1:0.
- R5: cfg_req, cfg_addr, cfg_be, cfg_we and cfg_wdata hold steady until cfg_done. cpu_ack is high in the cycle cfg_done is high. On a read, cpu_rdata is then cfg_rdata shifted right by 8 times address bits 1:0 and masked to the size width.
- R6: A one-byte read of 0xBFFFFFF0 raises iack_req in the cycle after the strobe. The request is held until iack_done. cpu_ack is high in that cycle, with cpu_rdata equal to the zero-extended iack_vec.
- R7: A write, or a read wider than one byte, at 0xBFFFFFF0 raises no request. It is treated as an unmapped access.
- R8: An unmapped access raises no request. cpu_ack is high for exactly one cycle, the cycle after the strobe is sampled, with cpu_rdata all ones.
- R9: Pin p (0..3 for pins A..D) of device d uses bit d*4+p of dev_irq. It drives host line (p + d) mod 2. Each of host_irq[1:0] is the OR of every pin mapped to it, and host_irq[3:2] stay low.
- R10: While rst_n is low, cfg_req, iack_req and cpu_ack are low.
- R11: Strobes that arrive while a request is outstanding are ignored. They cause no request and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | CPU byte address |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_size | input | 2 | Transfer size code |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | Access complete |
| cfg_req | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Configuration write |
| cfg_addr | output | 15 | Device number and register address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Lane-aligned read data |
| cfg_done | input | 1 | Target completion, one cycle |
| iack_req | output | 1 | Interrupt-acknowledge request |
| iack_vec | input | 8 | Vector from interrupt controller |
| iack_done | input | 1 | Vector valid, one cycle |
| dev_irq | input | 16 | Device interrupt pins, four per device |
| host_irq | output | 4 | Host interrupt lines |

## Verification
The device-number decode is tried with several select patterns. One has a single select bit set. One has several bits set, to tell lowest-first from highest-first scanning. One has no bit set, which must give 11. One sets only the top select bit. The lane logic is tried with every size at several offsets. These include offsets where the transfer runs past lane 3, which separates truncation from wrap-around. Window edges, the acknowledge location with legal and illegal sizes, strobes during a pending request, and interrupt patterns that set one pin, pins of the same parity, and pins of mixed parity are each compared against a behavioural model on every clock.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_IACK = 2'd2,
    ST_MISS = 2'd3
  } cfgwin_state_e;

  // Byte-enable pattern for a transfer size code before lane shifting.
  function automatic logic [3:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 4'b0001;
      2'd1:    size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  endfunction

  // Bit mask keeping the low bytes of a right-justified value.
  function automatic logic [31:0] size_keep(input logic [1:0] sz);
    case (sz)
      2'd0:    size_keep = 32'h0000_00FF;
      2'd1:    size_keep = 32'h0000_FFFF;
      default: size_keep = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate #(
  parameter int          AW        = 32,
  parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
  parameter int          WIN_BITS  = 22,
  parameter int          REG_BITS  = 11,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
  localparam int         SEL_W     = WIN_BITS - REG_BITS,
  localparam int         DEV_W     = $clog2(SEL_W + 1),
  localparam int         CA_W      = REG_BITS + DEV_W
) (
  input  logic [AW-1:0]   addr,
  output logic            in_win,
  output logic            is_iack,
  output logic [CA_W-1:0] cfg_addr
);

  logic [SEL_W-1:0] sel;
  logic [DEV_W-1:0] dev;

  assign sel     = addr[WIN_BITS-1:REG_BITS];
  assign in_win  = (addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);
  assign is_iack = (addr == IACK_ADDR[AW-1:0]);

  // Lowest set select bit wins; no bit set gives SEL_W.
  always_comb begin
    dev = DEV_W'(SEL_W);
    for (int i = SEL_W - 1; i >= 0; i--) begin
      if (sel[i]) dev = DEV_W'(i);
    end
  end

  assign cfg_addr = {dev, addr[REG_BITS-1:0]};

endmodule

// File: rtl/cfgwin_lanes.sv
module cfgwin_lanes
  import cfgwin_pkg::*;
(
  input  logic [1:0]  lane,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic [31:0] cfg_rdata,
  output logic [3:0]  be,
  output logic [31:0] wdata_sh,
  output logic [31:0] rdata_sh
);

  logic [7:0] be_wide;

  assign be_wide  = {4'b0000, size_mask(size)} << lane;
  assign be       = be_wide[3:0];
  assign wdata_sh = wdata << {lane, 3'b000};
  assign rdata_sh = (cfg_rdata >> {lane, 3'b000}) & size_keep(size);

endmodule

// File: rtl/cfgwin_irqmap.sv
module cfgwin_irqmap #(
  parameter int  NDEV       = 4,
  parameter int  PINS       = 4,
  parameter int  HOST_LINES = 4,
  parameter int  SWZ_LINES  = 2,
  localparam int IN_W       = NDEV * PINS
) (
  input  logic [IN_W-1:0]       dev_irq,
  output logic [HOST_LINES-1:0] host_irq
);

  for (genvar k = 0; k < HOST_LINES; k++) begin : g_line
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int d = 0; d < NDEV; d++) begin
        for (int p = 0; p < PINS; p++) begin
          if (((p + d) % SWZ_LINES) == k) acc = acc | dev_irq[d*PINS + p];
        end
      end
    end
    assign host_irq[k] = acc;
  end

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h8080_0000,
  parameter int          WIN_BYTES  = 32'h0040_0000,
  parameter int          REG_BITS   = 11,
  parameter logic [31:0] IACK_ADDR  = 32'hBFFF_FFF0,
  parameter int          NDEV       = 4,
  parameter int          PINS       = 4,
  parameter int          HOST_LINES = 4,
  localparam int         WIN_BITS   = $clog2(WIN_BYTES),
  localparam int         SEL_W      = WIN_BITS - REG_BITS,
  localparam int         DEV_W      = $clog2(SEL_W + 1),
  localparam int         CA_W       = REG_BITS + DEV_W,
  localparam int         IRQ_W      = NDEV * PINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [31:0]           cpu_addr,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [1:0]            cpu_size,
  input  logic [31:0]           cpu_wdata,
  output logic [31:0]           cpu_rdata,
  output logic                  cpu_ack,
  output logic                  cfg_req,
  output logic                  cfg_we,
  output logic [CA_W-1:0]       cfg_addr,
  output logic [3:0]            cfg_be,
  output logic [31:0]           cfg_wdata,
  input  logic [31:0]           cfg_rdata,
  input  logic                  cfg_done,
  output logic                  iack_req,
  input  logic [7:0]            iack_vec,
  input  logic                  iack_done,
  input  logic [IRQ_W-1:0]      dev_irq,
  output logic [HOST_LINES-1:0] host_irq
);

  cfgwin_state_e    state;
  logic [1:0]       lat_lane;
  logic [1:0]       lat_size;
  logic [31:0]      lat_wdata;
  logic             lat_we;
  logic [CA_W-1:0]  lat_caddr;

  // Named internal events
  logic             strobe;
  logic             hit_win;
  logic             hit_iack;
  logic             iack_legal;
  logic [CA_W-1:0]  live_caddr;
  logic [31:0]      rd_shifted;
  logic             cfg_finish;
  logic             iack_finish;

  assign strobe      = cpu_rd | cpu_wr;
  assign iack_legal  = hit_iack & cpu_rd & ~cpu_wr & (cpu_size == 2'd0);
  assign cfg_finish  = (state == ST_CFG) & cfg_done;
  assign iack_finish = (state == ST_IACK) & iack_done;

  cfgwin_xlate #(
    .AW       (32),
    .WIN_BASE (WIN_BASE),
    .WIN_BITS (WIN_BITS),
    .REG_BITS (REG_BITS),
    .IACK_ADDR(IACK_ADDR)
  ) u_xlate (
    .addr    (cpu_addr),
    .in_win  (hit_win),
    .is_iack (hit_iack),
    .cfg_addr(live_caddr)
  );

  cfgwin_lanes u_lanes (
    .lane     (lat_lane),
    .size     (lat_size),
    .wdata    (lat_wdata),
    .cfg_rdata(cfg_rdata),
    .be       (cfg_be),
    .wdata_sh (cfg_wdata),
    .rdata_sh (rd_shifted)
  );

  cfgwin_irqmap #(
    .NDEV      (NDEV),
    .PINS      (PINS),
    .HOST_LINES(HOST_LINES)
  ) u_irq (
    .dev_irq (dev_irq),
    .host_irq(host_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_lane  <= '0;
      lat_size  <= '0;
      lat_wdata <= '0;
      lat_we    <= 1'b0;
      lat_caddr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe) begin
            lat_lane  <= cpu_addr[1:0];
            lat_size  <= cpu_size;
            lat_wdata <= cpu_wdata;
            lat_we    <= cpu_wr;
            lat_caddr <= live_caddr;
            if (hit_win)         state <= ST_CFG;
            else if (iack_legal) state <= ST_IACK;
            else                 state <= ST_MISS;
          end
        end
        ST_CFG:  if (cfg_done)  state <= ST_IDLE;
        ST_IACK: if (iack_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cfg_req  = (state == ST_CFG);
  assign cfg_we   = lat_we;
  assign cfg_addr = lat_caddr;
  assign iack_req = (state == ST_IACK);
  assign cpu_ack  = cfg_finish | iack_finish | (state == ST_MISS);

  always_comb begin
    if (state == ST_CFG)       cpu_rdata = rd_shifted;
    else if (state == ST_IACK) cpu_rdata = {24'h0, iack_vec};
    else                       cpu_rdata = '1;
  end

  // Assertions
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_done |=> cfg_req && $stable(cfg_addr) && $stable(cfg_be)
                             && $stable(cfg_we) && $stable(cfg_wdata));

  p_iack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && !iack_done |=> iack_req);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && iack_req));

  p_iack_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_req) |-> $past(cpu_rd) && !$past(cpu_wr) && $past(cpu_size) == 2'd0);

  p_miss_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !cfg_req && !iack_req |-> cpu_rdata == '1);

  p_miss_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !cfg_req && !iack_req |=> !cpu_ack);

  p_dev_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_addr[CA_W-1:REG_BITS] <= DEV_W'(SEL_W));

  p_be_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_be != 4'b0000);

endmodule

// File: tb/cfgwin_decoder_test.sv
`timescale 1ns/1ps
module cfgwin_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ack;
  logic        cfg_req;
  logic        cfg_we;
  logic [14:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;
  logic        cfg_done = 1'b0;
  logic        iack_req;
  logic [7:0]  iack_vec = '0;
  logic        iack_done = 1'b0;
  logic [15:0] dev_irq = '0;
  logic [3:0]  host_irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit exp_cfg = 1'b0;
  bit exp_iack = 1'b0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  cfgwin_decoder uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_done(cfg_done),
    .iack_req(iack_req), .iack_vec(iack_vec), .iack_done(iack_done),
    .dev_irq(dev_irq), .host_irq(host_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Per-clock comparison of request lines with the model state.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      finish_run();
    end
    if (running) begin
      #1;
      chk(cfg_req == exp_cfg, "R1/R11 cfg_req", 32'(cfg_req), 32'(exp_cfg));
      chk(iack_req == exp_iack, "R6/R11 iack_req", 32'(iack_req), 32'(exp_iack));
    end
  end

  // ---- behavioural model ----
  function automatic int m_kind(input logic [31:0] a, input bit we, input logic [1:0] sz);
    if (a >= 32'h8080_0000 && a < 32'h80C0_0000) return 0;
    if (a == 32'hBFFF_FFF0 && !we && sz == 2'd0) return 1;
    return 2;
  endfunction

  function automatic logic [14:0] m_caddr(input logic [31:0] a);
    int dev;
    dev = 11;
    for (int b = 21; b >= 11; b--) if (a[b]) dev = b - 11;
    return {4'(dev), a[10:0]};
  endfunction

  function automatic int m_bytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] m_be(input logic [31:0] a, input logic [1:0] sz);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < m_bytes(sz); i++) if (a[1:0] + i < 4) r[a[1:0] + i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_rd(input logic [31:0] raw, input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < m_bytes(sz); i++)
      if (a[1:0] + i < 4) r[8*i +: 8] = raw[8*(a[1:0] + i) +: 8];
    return r;
  endfunction

  function automatic logic [3:0] m_irq(input logic [15:0] pins);
    logic [3:0] r;
    r = '0;
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 4; p++)
        if (pins[d*4 + p]) r[(p + d) % 2] = 1'b1;
    return r;
  endfunction

  task automatic access(input bit we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int delay, input logic [31:0] resp,
                        input bit poke);
    int kind;
    kind = m_kind(a, we, sz);
    @(negedge clk);
    cpu_addr = a; cpu_size = sz; cpu_wdata = wd; cpu_rd = !we; cpu_wr = we;
    exp_cfg = (kind == 0); exp_iack = (kind == 1);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    if (kind == 2) begin
      chk(cpu_ack == 1'b1, "R8 miss ack", 32'(cpu_ack), 32'd1);
      chk(cpu_rdata == 32'hFFFF_FFFF, "R8 miss rdata", cpu_rdata, 32'hFFFF_FFFF);
      @(negedge clk);
      chk(cpu_ack == 1'b0, "R8 single ack", 32'(cpu_ack), 32'd0);
      return;
    end
    if (kind == 0) begin
      chk(cfg_addr[10:0] == a[10:0], "R2 register bits", 32'(cfg_addr[10:0]), 32'(a[10:0]));
      chk(cfg_addr == m_caddr(a), "R3 device number", 32'(cfg_addr), 32'(m_caddr(a)));
      chk(cfg_we == we, "R1 cfg_we", 32'(cfg_we), 32'(we));
      chk(cfg_be == m_be(a, sz), "R4 byte enables", 32'(cfg_be), 32'(m_be(a, sz)));
      if (we) chk(cfg_wdata == (wd << (8*a[1:0])), "R4 write lanes", cfg_wdata, wd << (8*a[1:0]));
    end
    for (int i = 0; i < delay; i++) begin
      chk(cpu_ack == 1'b0, "R5 no early ack", 32'(cpu_ack), 32'd0);
      if (poke && i == 0) begin
        cpu_addr = 32'h1000_0000; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = '0;
        chk(cpu_ack == 1'b0, "R11 strobe while busy", 32'(cpu_ack), 32'd0);
      end else begin
        @(negedge clk);
      end
      if (kind == 0) chk(cfg_addr == m_caddr(a), "R5 address held", 32'(cfg_addr), 32'(m_caddr(a)));
    end
    if (kind == 0) begin
      cfg_rdata = resp; cfg_done = 1'b1;
    end else begin
      iack_vec = resp[7:0]; iack_done = 1'b1;
    end
    #1;
    chk(cpu_ack == 1'b1, "R5/R6 ack with done", 32'(cpu_ack), 32'd1);
    if (kind == 0 && !we)
      chk(cpu_rdata == m_rd(resp, a, sz), "R5 read lanes", cpu_rdata, m_rd(resp, a, sz));
    if (kind == 1)
      chk(cpu_rdata == {24'h0, resp[7:0]}, "R6 vector", cpu_rdata, {24'h0, resp[7:0]});
    exp_cfg = 1'b0; exp_iack = 1'b0;
    @(negedge clk);
    cfg_done = 1'b0; iack_done = 1'b0; cfg_rdata = '0;
    chk(cpu_ack == 1'b0, "R5/R11 ack drops", 32'(cpu_ack), 32'd0);
  endtask

  task automatic irq_pattern(input logic [15:0] pins);
    @(negedge clk);
    dev_irq = pins;
    #1;
    chk(host_irq == m_irq(pins), "R9 host lines", 32'(host_irq), 32'(m_irq(pins)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_req == 1'b0, "R10 reset cfg_req", 32'(cfg_req), 32'd0);
    chk(iack_req == 1'b0, "R10 reset iack_req", 32'(iack_req), 32'd0);
    chk(cpu_ack == 1'b0, "R10 reset ack", 32'(cpu_ack), 32'd0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5: single select bit, four-byte read
    access(1'b0, 32'h8080_0814, 2'd2, '0, 2, 32'h1234_5678, 1'b0);
    // R3: several select bits, lowest wins
    access(1'b0, 32'h8082_2008, 2'd2, '0, 0, 32'hCAFE_F00D, 1'b0);
    // R3: no select bit -> 11
    access(1'b0, 32'h8080_0004, 2'd2, '0, 1, 32'h0BAD_BEEF, 1'b0);
    // R3: top select bit only -> 10
    access(1'b0, 32'h80A0_0100, 2'd2, '0, 1, 32'h5555_AAAA, 1'b0);
    // R1: last word of window, all select bits
    access(1'b0, 32'h80BF_FFFC, 2'd2, '0, 0, 32'h0102_0304, 1'b0);
    // R4: byte write in lane 3, halfword write in lane 1
    access(1'b1, 32'h8081_0003, 2'd0, 32'h0000_00AB, 1, '0, 1'b0);
    access(1'b1, 32'h8084_0041, 2'd1, 32'h0000_BEEF, 0, '0, 1'b0);
    // R4 R5: halfword reads in lane 2 and lane 3 (truncated)
    access(1'b0, 32'h8080_1002, 2'd1, '0, 1, 32'hA1B2_C3D4, 1'b0);
    access(1'b0, 32'h8080_1003, 2'd1, '0, 1, 32'hA1B2_C3D4, 1'b0);
    // R4: byte read lane 1
    access(1'b0, 32'h8088_0011, 2'd0, '0, 3, 32'h0000_7700, 1'b0);
    // R1 R8: just below and just past the window
    access(1'b0, 32'h807F_FFFF, 2'd0, '0, 0, '0, 1'b0);
    access(1'b1, 32'h80C0_0000, 2'd2, 32'h1, 0, '0, 1'b0);
    // R6: legal acknowledge read
    access(1'b0, 32'hBFFF_FFF0, 2'd0, '0, 2, 32'h0000_002A, 1'b0);
    // R7: wide read and write at acknowledge address
    access(1'b0, 32'hBFFF_FFF0, 2'd1, '0, 0, '0, 1'b0);
    access(1'b1, 32'hBFFF_FFF0, 2'd0, 32'h5, 0, '0, 1'b0);
    // R11: strobe during pending request
    access(1'b0, 32'h8090_0020, 2'd2, '0, 3, 32'hDEAD_0001, 1'b1);
    access(1'b0, 32'hBFFF_FFF0, 2'd0, '0, 3, 32'h0000_0091, 1'b1);
    @(negedge clk);
    chk(cpu_ack == 1'b0, "R11 nothing after poke", 32'(cpu_ack), 32'd0);

    // R9: interrupt swizzle
    irq_pattern(16'h0001);
    irq_pattern(16'h0010);
    irq_pattern(16'h0024);
    irq_pattern(16'h5A5A);
    irq_pattern(16'h8000);
    irq_pattern(16'hFFFF);
    irq_pattern(16'h0000);

    repeat (3) @(negedge clk);
    running = 1'b0;
    finish_run();
  end

endmodule